// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block maps a 32-bit virtual address to a 30-bit physical address in two dependent steps. The top bits of the address pick one of eight segment descriptors, held in registers. Each descriptor gives the base address of that segment's page table and the number of entries the table holds. The middle bits form a virtual page number, which is checked against the descriptor's entry count. If the number is in range, the block reads one page table word from an external memory at base plus page number. The physical page number in that word is then joined to the untouched page offset.

Software fills the descriptors through a simple write port. A client hands over one address at a time on a valid/ready handshake and gets a one-cycle response carrying either the physical address or a fault flag. A descriptor whose entry count is zero marks an unused segment. Every access to such a segment faults.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `mem_req` are 0. Every descriptor has a count of zero, so any access faults.
- R2: The virtual address splits as segment = bits [31:29], page number = bits [28:12] and offset = bits [11:0]. The offset appears unchanged in `rsp_paddr[11:0]` of every non-faulting response.
- R3: When `cfg_we` is high on a clock edge, descriptor `cfg_seg` takes `cfg_base` and `cfg_count`. Later translations through that segment use the new values.
- R4: The table read address on `mem_addr` is the descriptor base plus the zero-extended page number, modulo 2^30. It and `mem_req` stay steady until `mem_rvalid` is seen.
- R5: If the page number is greater than or equal to the descriptor count, the response has `rsp_fault`=1 and `rsp_paddr`=0, and `mem_req` is never raised for that translation. A page number of count-1 still translates.
- R6: A segment whose count is zero faults for every page number, including 0.
- R7: On a non-faulting response, `rsp_paddr[29:12]` equals the `mem_rdata` value returned with `mem_rvalid`, and `rsp_fault` is 0.
- R8: `req_ready` drops in the cycle after acceptance and stays low up to and including the `rsp_valid` cycle. `rsp_valid` lasts one cycle, and `req_ready` is 1 again in the cycle after it.
- R9: A faulting response appears exactly two clock edges after the accepting edge.
- R10: The block waits any number of cycles for `mem_rvalid`. A `mem_rvalid` pulse while `mem_req` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_seg | input | 3 | Descriptor index to write |
| cfg_base | input | 30 | Page table base address |
| cfg_count | input | 18 | Page table entry count (0 = unused segment) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| mem_req | output | 1 | Page table read request |
| mem_addr | output | 30 | Page table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 18 | Physical page number read back |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Page number out of range for the segment |
| rsp_paddr | output | 30 | Physical address (0 on fault) |

## Verification
The bench aims at the edge of the range check: a page number of count-1 must translate and a page number equal to the count must fault. A design that used `>` in place of `>=` would read one entry past the end of the table. Zero-count segments are tried at page 0, where an unsigned compare written the wrong way would let the read through. A base near the top of the address space shows whether the entry address wraps at 30 bits or is cut off wrongly. Varied memory latency and stray read strobes while idle show whether the state machine latches data too early or without a request, which would give a wrong or spurious response.

// File: rtl/seg_page_xlate.sv
module seg_page_xlate #(
  parameter int VA_W  = 32,
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PPN_W = 18,
  parameter int AW    = 30,
  localparam int VPN_W = VA_W - SEG_W - OFF_W,
  localparam int CNT_W = VPN_W + 1,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEG_W-1:0] cfg_seg,
  input  logic [AW-1:0]    cfg_base,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [PPN_W-1:0] mem_rdata,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);
  localparam int NSEG = 1 << SEG_W;

  typedef enum logic [1:0] {S_IDLE, S_SEG, S_MEM, S_DONE} state_t;

  state_t           state;
  logic [AW-1:0]    base_q  [NSEG];
  logic [CNT_W-1:0] count_q [NSEG];
  logic [VA_W-1:0]  vaddr_q;
  logic [AW-1:0]    addr_q;
  logic [PPN_W-1:0] ppn_q;
  logic             fault_q;

  logic [SEG_W-1:0] seg;
  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;
  logic             out_of_range;

  assign seg = vaddr_q[VA_W-1 -: SEG_W];
  assign vpn = vaddr_q[OFF_W +: VPN_W];
  assign off = vaddr_q[OFF_W-1:0];
  assign out_of_range = {1'b0, vpn} >= count_q[seg];

  assign req_ready = (state == S_IDLE);
  assign mem_req   = (state == S_MEM);
  assign mem_addr  = addr_q;
  assign rsp_valid = (state == S_DONE);
  assign rsp_fault = fault_q;
  assign rsp_paddr = fault_q ? '0 : {ppn_q, off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]  <= '0;
        count_q[i] <= '0;
      end
    end else if (cfg_we) begin
      base_q[cfg_seg]  <= cfg_base;
      count_q[cfg_seg] <= cfg_count;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      vaddr_q <= '0;
      addr_q  <= '0;
      ppn_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            fault_q <= 1'b0;
            state   <= S_SEG;
          end
        S_SEG:
          if (out_of_range) begin
            fault_q <= 1'b1;
            state   <= S_DONE;
          end else begin
            addr_q <= base_q[seg] + AW'(vpn);
            state  <= S_MEM;
          end
        S_MEM:
          if (mem_rvalid) begin
            ppn_q <= mem_rdata;
            state <= S_DONE;
          end
        default:
          state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_page_xlate_chk.sv
module seg_page_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PPN_W = 18,
  parameter int AW    = 30,
  localparam int VPN_W = VA_W - SEG_W - OFF_W,
  localparam int CNT_W = VPN_W + 1,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [SEG_W-1:0] cfg_seg,
  input logic [AW-1:0]    cfg_base,
  input logic [CNT_W-1:0] cfg_count,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             mem_req,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_rvalid,
  input logic [PPN_W-1:0] mem_rdata,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr
);
  logic             accept;
  logic             mem_seen;
  logic [OFF_W-1:0] off_q;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_seen <= 1'b0;
      off_q    <= '0;
    end else if (accept) begin
      mem_seen <= 1'b0;
      off_q    <= req_vaddr[OFF_W-1:0];
    end else if (mem_req) begin
      mem_seen <= 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) $rose(rst_n) |-> req_ready && !rsp_valid && !mem_req);

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == off_q);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  assert_fault_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !mem_seen && rsp_paddr == '0);

  assert_ppn_passed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid |=> rsp_valid && !rsp_fault && rsp_paddr[PA_W-1:OFF_W] == $past(mem_rdata));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_ready_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready && !rsp_valid);

  assert_fault_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> $past(accept, 2));

  assert_stray_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && mem_rvalid |=> !rsp_valid);
endmodule

bind seg_page_xlate seg_page_xlate_chk #(
  .VA_W(VA_W), .SEG_W(SEG_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .AW(AW)
) u_chk (.*);

// File: tb/test_seg_page_xlate.sv
`timescale 1ns/1ps
module test_seg_page_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_seg = '0;
  logic [29:0] cfg_base = '0;
  logic [17:0] cfg_count = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        mem_req;
  logic [29:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [17:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [29:0] rsp_paddr;

  int checks = 0;
  int errors = 0;
  int lat_cfg = 0;
  int cnt = 0;
  int nreq_total = 0;
  logic        stray = 1'b0;
  logic        prev_req = 1'b0;
  logic [29:0] last_addr = '0;

  always #2.5 clk = ~clk;

  seg_page_xlate i_seg_page_xlate (.*);

  function automatic logic [17:0] ppn_of(input logic [29:0] a);
    return 18'(a * 30'd13 + 30'd7);
  endfunction

  always @(negedge clk) begin
    prev_req <= mem_req;
    if (mem_req && !prev_req) nreq_total <= nreq_total + 1;
    if (mem_req) begin
      last_addr <= mem_addr;
      if (cnt >= lat_cfg) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= ppn_of(mem_addr);
        cnt <= 0;
      end else begin
        mem_rvalid <= 1'b0;
        cnt <= cnt + 1;
      end
    end else begin
      cnt <= 0;
      mem_rvalid <= stray;
      mem_rdata  <= 18'h3FFFF;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_seg(input logic [2:0] s, input logic [29:0] b, input logic [17:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = s; cfg_base = b; cfg_count = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input int lat,
                       output logic fault, output logic [29:0] pa, output int cyc, output int nreq);
    int n0;
    lat_cfg = lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n0 = nreq_total;
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 1000) begin
      check(!req_ready, "R8 busy", 64'(req_ready), 64'd0);
      @(negedge clk);
      cyc++;
    end
    fault = rsp_fault; pa = rsp_paddr;
    check(!req_ready, "R8 busy at rsp", 64'(req_ready), 64'd0);
    @(negedge clk);
    check(!rsp_valid && req_ready, "R8 pulse", 64'({rsp_valid, req_ready}), 64'b01);
    nreq = nreq_total - n0;
  endtask

  task automatic expect_ok(input logic [2:0] s, input logic [16:0] vpn, input logic [11:0] off,
                           input logic [29:0] base, input int lat, input string tag);
    logic f; logic [29:0] pa; int cyc; int nr;
    logic [29:0] ea;
    ea = base + 30'(vpn);
    xlate({s, vpn, off}, lat, f, pa, cyc, nr);
    check(!f, {tag, " fault"}, 64'(f), 64'd0);
    check(pa == {ppn_of(ea), off}, {tag, " paddr"}, 64'(pa), 64'({ppn_of(ea), off}));
    check(last_addr == ea, "R4 entry addr", 64'(last_addr), 64'(ea));
    check(nr == 1, {tag, " one read"}, 64'(nr), 64'd1);
  endtask

  task automatic expect_fault(input logic [2:0] s, input logic [16:0] vpn, input string tag);
    logic f; logic [29:0] pa; int cyc; int nr;
    xlate({s, vpn, 12'hABC}, 0, f, pa, cyc, nr);
    check(f, {tag, " fault"}, 64'(f), 64'd1);
    check(pa == '0, {tag, " paddr zero"}, 64'(pa), 64'd0);
    check(nr == 0, "R5 no read", 64'(nr), 64'd0);
    check(cyc == 2, "R9 fault timing", 64'(cyc), 64'd2);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req, "R1 reset state",
          64'({req_ready, rsp_valid, mem_req}), 64'b100);
    expect_fault(3'd2, 17'd0, "R1 empty table");
  endtask

  task automatic t_basic();
    set_seg(3'd0, 30'h0000_1000, 18'd16);
    expect_ok(3'd0, 17'd5, 12'h345, 30'h0000_1000, 0, "R7 basic");
  endtask

  task automatic t_segs();
    set_seg(3'd5, 30'h0123_4560, 18'd1000);
    set_seg(3'd7, 30'h2000_0000, 18'h20000);
    expect_ok(3'd5, 17'd999, 12'hFFF, 30'h0123_4560, 3, "R2 seg5");
    expect_ok(3'd7, 17'h1FFFF, 12'h000, 30'h2000_0000, 6, "R10 latency");
    expect_ok(3'd5, 17'd0, 12'h001, 30'h0123_4560, 1, "R2 seg5 low");
  endtask

  task automatic t_bound();
    set_seg(3'd3, 30'h0000_8000, 18'd10);
    expect_ok(3'd3, 17'd9, 12'h777, 30'h0000_8000, 0, "R5 last entry");
    expect_fault(3'd3, 17'd10, "R5 at count");
    expect_fault(3'd3, 17'h1FFFF, "R5 far");
  endtask

  task automatic t_zero();
    set_seg(3'd6, 30'h0000_4000, 18'd0);
    expect_fault(3'd6, 17'd0, "R6 zero count");
  endtask

  task automatic t_rewrite();
    set_seg(3'd3, 30'h0000_9000, 18'd11);
    expect_ok(3'd3, 17'd10, 12'h010, 30'h0000_9000, 2, "R3 rewrite");
  endtask

  task automatic t_wrap();
    set_seg(3'd1, 30'h3FFF_FFFF, 18'd4);
    expect_ok(3'd1, 17'd2, 12'h5A5, 30'h3FFF_FFFF, 0, "R4 wrap");
  endtask

  task automatic t_stray();
    @(negedge clk);
    stray = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(req_ready && !rsp_valid, "R10 stray ignored", 64'({req_ready, rsp_valid}), 64'b10);
    end
    stray = 1'b0;
    expect_ok(3'd0, 17'd15, 12'h0F0, 30'h0000_1000, 2, "R10 after stray");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_segs();
    t_bound();
    t_zero();
    t_rewrite();
    t_wrap();
    t_stray();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule